// File: doc/BRIEF.md
# Breathing Status LED Generator

This block drives one or two status LEDs with a slow "breathing" glow. A cycle divider turns the core clock into a one-millisecond tick, and a free-running millisecond count advances on every tick. On each tick, every channel takes the count modulo its current breathing period and folds that phase into a triangle about the half period. It then scales the folded phase to the channel's peak brightness and loads the result into an 8-bit up-counting PWM comparator. The folding and scaling use two divisions, which a small shift-subtract divider per channel works through in the gap between ticks.

The surrounding firmware or control logic reports its status with a 3-bit code and a one-cycle strobe. Each status code picks the breathing period of one channel. The link-status codes go to the secondary channel when the build has one, and to the primary channel otherwise. A polarity parameter handles LEDs wired active-high, for which the compare value is the complement of the computed duty.

Top module: `breath_led`

## Requirements
- R1: The millisecond count advances by exactly one every CYCLES_PER_TICK clocks, counted from reset release, and a new duty calculation starts on every tick.
- R2: The phase is the millisecond count modulo the channel period. When the phase is larger than half the period (period shifted right by one), the phase used is the period minus the phase.
- R3: The raw duty is the peak times the folded phase divided by the half period, rounded down. The peak is 0x4F on the primary channel and 0x8F on the secondary channel, so the raw duty never exceeds the channel's peak.
- R4: A strobed status code sets the primary period as follows: 0 sets PERIOD_LONG (3000), 1 and 2 set PERIOD_MID (300), 3 sets PERIOD_SHORT (100), and 4 sets PERIOD_LONG.
- R5: Code 5 sets PERIOD_LONG and code 6 sets PERIOD_MID. Both go to the secondary channel when HAS_SECOND is 1 and to the primary channel when HAS_SECOND is 0.
- R6: Code 7, and any code presented while the strobe is low, leaves both periods unchanged.
- R7: A period change is first used at the tick after the strobe. A status change never resets the millisecond count; only reset does.
- R8: A period of zero gives a raw duty of zero.
- R9: With ACTIVE_HIGH set, the compare value is 255 minus the raw duty. Otherwise the compare value is the raw duty itself.
- R10: The PWM counter runs 0 to 255 and wraps. It steps once every PWM_PRESCALE clocks. An output is high in the clock after a counter value lower than its compare value.
- R11: Reset clears both periods, the millisecond count and the PWM outputs. The compare values reset to 255 if ACTIVE_HIGH is set and to 0 otherwise.
- R12: With HAS_SECOND set to 0, the secondary output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| status_code | input | 3 | Status code, read only while status_stb is high |
| status_stb | input | 1 | One-cycle strobe that accepts status_code |
| pwm_pri | output | 1 | PWM drive for the primary LED |
| pwm_sec | output | 1 | PWM drive for the secondary LED (low in single-channel builds) |

## Verification
The duty calculation is sampled at ticks that fall on the rising slope, exactly at the half period, one past the fold, and near the end of a period. This separates a correct fold from an off-by-one at the peak and from a missing fold. Each status code is applied while the millisecond count keeps running. A period that wrongly restarts the phase, or that takes effect within the same tick, therefore gives a different duty. Reserved and unstrobed codes are placed just before ticks whose duty would change if they were taken. A second build (active-high, single channel) and a third (prescale of 16) tell the polarity, link-code routing and counter step rate apart.

// File: rtl/breath_pkg.sv
`timescale 1ns/1ps
package breath_pkg;
    typedef enum logic [2:0] {
        ST_MOUNTED   = 3'd0,
        ST_BOOT      = 3'd1,
        ST_UNMOUNT   = 3'd2,
        ST_WR_BEGIN  = 3'd3,
        ST_WR_END    = 3'd4,
        ST_LINK_UP   = 3'd5,
        ST_LINK_DOWN = 3'd6,
        ST_RESERVED  = 3'd7
    } status_e;

    typedef enum logic [1:0] {
        DU_IDLE  = 2'd0,
        DU_MOD   = 2'd1,
        DU_SCALE = 2'd2
    } du_phase_e;
endpackage

// File: rtl/breath_tick.sv
`timescale 1ns/1ps
module breath_tick #(
    parameter int CYCLES_PER_TICK = 16000,
    parameter int MS_W            = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic            tick,
    output logic [MS_W-1:0] ms
);
    localparam int CW = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [MS_W-1:0] ms;
        logic            tick;
    } tk_s;

    tk_s tk_d, tk_q;

    always_comb begin
        tk_d      = tk_q;
        tk_d.tick = 1'b0;
        if (tk_q.cnt == CW'(CYCLES_PER_TICK - 1)) begin
            tk_d.cnt  = '0;
            tk_d.ms   = tk_q.ms + MS_W'(1);
            tk_d.tick = 1'b1;
        end else begin
            tk_d.cnt = tk_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tk_q <= '0;
        else     tk_q <= tk_d;
    end

    assign tick = tk_q.tick;
    assign ms   = tk_q.ms;
endmodule

// File: rtl/breath_duty.sv
`timescale 1ns/1ps
module breath_duty
    import breath_pkg::*;
#(
    parameter int         MS_W        = 32,
    parameter int         PER_W       = 16,
    parameter logic [7:0] PEAK        = 8'h4F,
    parameter bit         ACTIVE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MS_W-1:0]  ms,
    input  logic [PER_W-1:0] period,
    output logic [7:0]       cmp
);
    localparam int         CNT_W    = $clog2(MS_W);
    localparam logic [7:0] IDLE_CMP = ACTIVE_HIGH ? 8'hFF : 8'h00;

    typedef struct packed {
        du_phase_e        phase;
        logic [CNT_W-1:0] cnt;
        logic [MS_W-1:0]  num;
        logic [PER_W-1:0] rem;
        logic [PER_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [7:0]       cmp;
    } du_s;

    du_s du_d, du_q;

    logic [PER_W:0]   shifted;
    logic             fits;
    logic [PER_W-1:0] rem_n;
    logic [MS_W-1:0]  num_n;
    logic [PER_W-1:0] half;
    logic [PER_W-1:0] fold;
    logic [MS_W-1:0]  prod;
    logic [7:0]       raw;

    always_comb begin
        // one restoring shift-subtract step, shared by both divisions
        shifted = {du_q.rem, du_q.num[MS_W-1]};
        fits    = shifted >= {1'b0, du_q.div};
        rem_n   = fits ? PER_W'(shifted - {1'b0, du_q.div}) : PER_W'(shifted);
        num_n   = {du_q.num[MS_W-2:0], fits};
        half    = du_q.per >> 1;
        fold    = (rem_n > half) ? (du_q.per - rem_n) : rem_n;
        prod    = MS_W'(PEAK) * MS_W'(fold);
        raw     = num_n[7:0];

        du_d = du_q;
        case (du_q.phase)
            DU_IDLE: begin
                if (start) begin
                    if (period == '0) begin
                        du_d.cmp = IDLE_CMP;
                    end else begin
                        du_d.num   = ms;
                        du_d.div   = period;
                        du_d.per   = period;
                        du_d.rem   = '0;
                        du_d.cnt   = CNT_W'(MS_W - 1);
                        du_d.phase = DU_MOD;
                    end
                end
            end
            DU_MOD: begin
                du_d.rem = rem_n;
                du_d.num = num_n;
                du_d.cnt = du_q.cnt - CNT_W'(1);
                if (du_q.cnt == '0) begin
                    if (half == '0) begin
                        du_d.cmp   = IDLE_CMP;
                        du_d.phase = DU_IDLE;
                    end else begin
                        du_d.num   = prod;
                        du_d.div   = half;
                        du_d.rem   = '0;
                        du_d.cnt   = CNT_W'(MS_W - 1);
                        du_d.phase = DU_SCALE;
                    end
                end
            end
            DU_SCALE: begin
                du_d.rem = rem_n;
                du_d.num = num_n;
                du_d.cnt = du_q.cnt - CNT_W'(1);
                if (du_q.cnt == '0) begin
                    du_d.cmp   = ACTIVE_HIGH ? ~raw : raw;
                    du_d.phase = DU_IDLE;
                end
            end
            default: du_d.phase = DU_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            du_q     <= '0;
            du_q.cmp <= IDLE_CMP;
        end else begin
            du_q <= du_d;
        end
    end

    assign cmp = du_q.cmp;
endmodule

// File: rtl/breath_pwm.sv
`timescale 1ns/1ps
module breath_pwm #(
    parameter int NCH      = 2,
    parameter int PRESCALE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0][7:0] cmp,
    output logic [NCH-1:0]      pwm
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [7:0]       cnt;
        logic [NCH-1:0]   pwm;
    } pw_s;

    pw_s pw_d, pw_q;

    always_comb begin
        pw_d = pw_q;
        if (pw_q.pre == PRE_W'(PRESCALE - 1)) begin
            pw_d.pre = '0;
            pw_d.cnt = pw_q.cnt + 8'd1;
        end else begin
            pw_d.pre = pw_q.pre + PRE_W'(1);
        end
        for (int i = 0; i < NCH; i++) begin
            pw_d.pwm[i] = pw_q.cnt < cmp[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pw_q <= '0;
        else     pw_q <= pw_d;
    end

    assign pwm = pw_q.pwm;
endmodule

// File: rtl/breath_led.sv
`timescale 1ns/1ps
module breath_led
    import breath_pkg::*;
#(
    parameter int         CYCLES_PER_TICK = 16000,
    parameter int         PWM_PRESCALE    = 16,
    parameter bit         ACTIVE_HIGH     = 1'b0,
    parameter bit         HAS_SECOND      = 1'b1,
    parameter int         MS_W            = 32,
    parameter int         PER_W           = 16,
    parameter int         PERIOD_LONG     = 3000,
    parameter int         PERIOD_MID      = 300,
    parameter int         PERIOD_SHORT    = 100,
    parameter logic [7:0] PEAK_PRI        = 8'h4F,
    parameter logic [7:0] PEAK_SEC        = 8'h8F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] status_code,
    input  logic       status_stb,
    output logic       pwm_pri,
    output logic       pwm_sec
);
    localparam int               NCH     = HAS_SECOND ? 2 : 1;
    localparam logic [PER_W-1:0] P_LONG  = PER_W'(PERIOD_LONG);
    localparam logic [PER_W-1:0] P_MID   = PER_W'(PERIOD_MID);
    localparam logic [PER_W-1:0] P_SHORT = PER_W'(PERIOD_SHORT);

    typedef struct packed {
        logic [PER_W-1:0] pri;
        logic [PER_W-1:0] sec;
    } per_s;

    per_s per_d, per_q;

    logic                tick;
    logic [MS_W-1:0]     ms;
    logic [NCH-1:0][7:0] cmp;
    logic [NCH-1:0]      pwm;

    always_comb begin
        per_d = per_q;
        if (status_stb) begin
            case (status_e'(status_code))
                ST_MOUNTED:             per_d.pri = P_LONG;
                ST_BOOT, ST_UNMOUNT:    per_d.pri = P_MID;
                ST_WR_BEGIN:            per_d.pri = P_SHORT;
                ST_WR_END:              per_d.pri = P_LONG;
                ST_LINK_UP: begin
                    if (HAS_SECOND) per_d.sec = P_LONG;
                    else            per_d.pri = P_LONG;
                end
                ST_LINK_DOWN: begin
                    if (HAS_SECOND) per_d.sec = P_MID;
                    else            per_d.pri = P_MID;
                end
                default: per_d = per_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) per_q <= '0;
        else     per_q <= per_d;
    end

    breath_tick #(
        .CYCLES_PER_TICK(CYCLES_PER_TICK),
        .MS_W           (MS_W)
    ) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .ms  (ms)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        breath_duty #(
            .MS_W       (MS_W),
            .PER_W      (PER_W),
            .PEAK       ((ch == 0) ? PEAK_PRI : PEAK_SEC),
            .ACTIVE_HIGH(ACTIVE_HIGH)
        ) u_duty (
            .clk   (clk),
            .rst   (rst),
            .start (tick),
            .ms    (ms),
            .period((ch == 0) ? per_q.pri : per_q.sec),
            .cmp   (cmp[ch])
        );
    end

    breath_pwm #(
        .NCH     (NCH),
        .PRESCALE(PWM_PRESCALE)
    ) u_pwm (
        .clk(clk),
        .rst(rst),
        .cmp(cmp),
        .pwm(pwm)
    );

    assign pwm_pri = pwm[0];

    if (HAS_SECOND) begin : g_sec
        assign pwm_sec = pwm[NCH-1];
    end else begin : g_nosec
        assign pwm_sec = 1'b0;
    end
endmodule

// File: rtl/breath_led_chk.sv
`timescale 1ns/1ps
module breath_led_chk #(
    parameter int         CYCLES_PER_TICK = 16000,
    parameter bit         ACTIVE_HIGH     = 1'b0,
    parameter bit         HAS_SECOND      = 1'b1,
    parameter int         MS_W            = 32,
    parameter int         PER_W           = 16,
    parameter logic [7:0] PEAK_PRI        = 8'h4F,
    parameter logic [7:0] PEAK_SEC        = 8'h8F
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       status_code,
    input logic             status_stb,
    input logic             tick,
    input logic [MS_W-1:0]  ms,
    input logic [PER_W-1:0] per_pri,
    input logic [PER_W-1:0] per_sec,
    input logic [7:0]       cmp_pri,
    input logic [7:0]       cmp_sec,
    input logic             pwm_pri,
    input logic             pwm_sec
);
    localparam logic [7:0] ZERO_CMP = ACTIVE_HIGH ? 8'hFF : 8'h00;

    logic [31:0] gap_q;
    logic [7:0]  raw_pri, raw_sec;

    always_ff @(posedge clk) begin
        if (rst)       gap_q <= '0;
        else if (tick) gap_q <= 32'd1;
        else           gap_q <= gap_q + 32'd1;
    end

    assign raw_pri = ACTIVE_HIGH ? ~cmp_pri : cmp_pri;
    assign raw_sec = ACTIVE_HIGH ? ~cmp_sec : cmp_sec;

    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == 32'(CYCLES_PER_TICK));
    p_tick_due_r1: assert property (@(posedge clk) disable iff (rst)
        (gap_q == 32'(CYCLES_PER_TICK)) |-> tick);
    p_ms_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |-> $stable(ms));
    p_ms_step_r1: assert property (@(posedge clk) disable iff (rst)
        tick |-> ms == $past(ms) + MS_W'(1));
    p_peak_pri_r3: assert property (@(posedge clk) disable iff (rst)
        raw_pri <= PEAK_PRI);
    p_zero_period_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && per_pri == '0) |=> cmp_pri == ZERO_CMP);
    p_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !status_stb |=> ($stable(per_pri) && $stable(per_sec)));
    p_reserved_r6: assert property (@(posedge clk) disable iff (rst)
        (status_stb && status_code == 3'd7) |=> ($stable(per_pri) && $stable(per_sec)));
    p_pwm_off_r10: assert property (@(posedge clk) disable iff (rst)
        (cmp_pri == 8'h00) |=> !pwm_pri);

    if (HAS_SECOND) begin : g_two
        p_peak_sec_r3: assert property (@(posedge clk) disable iff (rst)
            raw_sec <= PEAK_SEC);
    end else begin : g_one
        p_sec_quiet_r12: assert property (@(posedge clk) disable iff (rst)
            !pwm_sec);
    end
endmodule

bind breath_led breath_led_chk #(
    .CYCLES_PER_TICK(CYCLES_PER_TICK),
    .ACTIVE_HIGH    (ACTIVE_HIGH),
    .HAS_SECOND     (HAS_SECOND),
    .MS_W           (MS_W),
    .PER_W          (PER_W),
    .PEAK_PRI       (PEAK_PRI),
    .PEAK_SEC       (PEAK_SEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .status_code(status_code),
    .status_stb (status_stb),
    .tick       (tick),
    .ms         (ms),
    .per_pri    (per_q.pri),
    .per_sec    (per_q.sec),
    .cmp_pri    (cmp[0]),
    .cmp_sec    (cmp[NCH-1]),
    .pwm_pri    (pwm_pri),
    .pwm_sec    (pwm_sec)
);

// File: tb/tb_breath_led.sv
`timescale 1ns/1ps
module tb_breath_led;
    localparam int T  = 400;
    localparam int NV = 15;
    // entry: tick index [19:4], status code [3:1], strobe [0]
    localparam logic [19:0] VEC [NV] = '{
        {16'd1,   3'd3, 1'b1},
        {16'd2,   3'd7, 1'b0},
        {16'd25,  3'd7, 1'b0},
        {16'd50,  3'd7, 1'b0},
        {16'd51,  3'd7, 1'b0},
        {16'd99,  3'd6, 1'b0},
        {16'd100, 3'd5, 1'b1},
        {16'd101, 3'd1, 1'b1},
        {16'd102, 3'd7, 1'b0},
        {16'd160, 3'd2, 1'b1},
        {16'd200, 3'd6, 1'b1},
        {16'd210, 3'd4, 1'b1},
        {16'd220, 3'd7, 1'b1},
        {16'd221, 3'd0, 1'b1},
        {16'd222, 3'd7, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] code = 3'd7;
    logic       stb = 1'b0;
    logic       pa1, pb1, pa2, pb2, pa3, pb3;

    always #2.5 clk = ~clk;

    breath_led #(.CYCLES_PER_TICK(T), .PWM_PRESCALE(1), .ACTIVE_HIGH(1'b0), .HAS_SECOND(1'b1)) dut (
        .clk(clk), .rst(rst), .status_code(code), .status_stb(stb), .pwm_pri(pa1), .pwm_sec(pb1));
    breath_led #(.CYCLES_PER_TICK(T), .PWM_PRESCALE(1), .ACTIVE_HIGH(1'b1), .HAS_SECOND(1'b0)) dut2 (
        .clk(clk), .rst(rst), .status_code(code), .status_stb(stb), .pwm_pri(pa2), .pwm_sec(pb2));
    breath_led #(.CYCLES_PER_TICK(T), .PWM_PRESCALE(16), .ACTIVE_HIGH(1'b1), .HAS_SECOND(1'b1)) dut3 (
        .clk(clk), .rst(rst), .status_code(3'd7), .status_stb(1'b0), .pwm_pri(pa3), .pwm_sec(pb3));

    int cyc;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    int per_a, per_b, per_2;
    int c_a1, c_b1, c_a2, c_b2, c_a3, c_b3;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int raw(input int msv, input int p, input int peak);
        int ph, h;
        if (p == 0) return 0;
        ph = msv % p;
        h  = p / 2;
        if (ph > h) ph = p - ph;
        if (h == 0) return 0;
        return peak * ph / h;
    endfunction

    task automatic upd(input logic [2:0] c);
        case (c)
            3'd0, 3'd4: per_a = 3000;
            3'd1, 3'd2: per_a = 300;
            3'd3:       per_a = 100;
            default: ;
        endcase
        case (c)
            3'd0, 3'd4: per_2 = 3000;
            3'd1, 3'd2: per_2 = 300;
            3'd3:       per_2 = 100;
            3'd5: begin per_b = 3000; per_2 = 3000; end
            3'd6: begin per_b = 300;  per_2 = 300;  end
            default: ;
        endcase
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic measure(input int n);
        c_a1 = 0; c_b1 = 0; c_a2 = 0; c_b2 = 0; c_a3 = 0; c_b3 = 0;
        repeat (n) begin
            @(negedge clk);
            c_a1 += int'(pa1); c_b1 += int'(pb1); c_a2 += int'(pa2);
            c_b2 += int'(pb2); c_a3 += int'(pa3); c_b3 += int'(pb3);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; stb = 1'b0; code = 3'd7;
        repeat (4) @(negedge clk);
        check("R11 primary low in reset", int'(pa1), 0);
        check("R11 active-high primary low in reset", int'(pa2), 0);
        rst = 1'b0;
        per_a = 0; per_b = 0; per_2 = 0;
    endtask

    task automatic strobe_at(input int c, input logic [2:0] v, input logic s);
        wait_cyc(c);
        code = v; stb = s;
        @(negedge clk);
        stb = 1'b0; code = 3'd7;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // reset state, tick 0: zero periods, R8 R11
        wait_cyc(100);
        measure(256);
        check("R11 R8 primary after reset", c_a1, 0);
        check("R11 R8 secondary after reset", c_b1, 0);
        check("R11 R9 active-high primary after reset", c_a2, 255);
        check("R12 single-channel secondary after reset", c_b2, 0);

        for (int i = 0; i < NV; i++) begin
            int k;
            logic [2:0] c;
            logic s;
            string tag;
            k = int'(VEC[i][19:4]);
            c = VEC[i][3:1];
            s = VEC[i][0];
            strobe_at(k * T + 60, c, s);
            wait_cyc(k * T + 100);
            measure(256);
            tag = $sformatf("%sR1 R2 R3 R4 R7 primary k=%0d",
                            (!s || c == 3'd7) ? "R6 " : "", k);
            check(tag, c_a1, raw(k, per_a, 8'h4F));
            check($sformatf("R3 R5 secondary k=%0d", k), c_b1, raw(k, per_b, 8'h8F));
            check($sformatf("R5 R9 single-channel primary k=%0d", k), c_a2, 255 - raw(k, per_2, 8'h4F));
            check($sformatf("R12 single-channel secondary k=%0d", k), c_b2, 0);
            if (s) upd(c);
        end

        // reset in mid-run: periods and count cleared
        do_reset();
        strobe_at(60, 3'd3, 1'b1);
        wait_cyc(100);
        measure(256);
        upd(3'd3);
        check("R11 primary after second reset", c_a1, 0);
        check("R11 R9 active-high primary after second reset", c_a2, 255);
        measure(4096);
        check("R10 prescale 16 primary high time", c_a3, 4080);
        check("R10 prescale 16 secondary high time", c_b3, 4080);
        wait_cyc(11 * T + 100);
        measure(256);
        check("R7 count restarts only on reset primary", c_a1, raw(11, 100, 8'h4F));
        check("R7 R9 count restarts only on reset single", c_a2, 255 - raw(11, 100, 8'h4F));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule